// File: doc/BRIEF.md
# Warp Branch Divergence Sequencer

This block tracks which lanes of a 32-lane warp are live and which program counter the warp fetches next, across conditional branches. Each cycle the front end presents the PC of the instruction being issued. When that instruction is a branch it also presents a strobe, a per-lane taken vector, the taken target, the fall-through PC and the PC where the two paths join again. The block returns the next PC within the same cycle and updates its registered lane mask at the clock edge.

If all live lanes agree, the branch is a plain jump and the mask stays as it is. If they disagree, the block saves a frame on an internal stack and runs the taken lanes first. When the issued PC reaches the join PC held in the top frame, it sends the warp back to the fall-through PC with the lanes that were left behind. When the issued PC reaches the join PC again, it pops the frame and restores the mask that was live before the split. Frames nest, so a split inside a split unwinds inner first. A split that finds the stack full sets a sticky overflow flag and is otherwise treated as a fall-through.

A cycle in which a join action happens is a redirect slot: the instruction at the join PC is not issued with the old mask. After a pop, the join PC is presented again with the restored mask.

Top module: `simt_reconv_unit`

## Requirements
- R1: Synchronous reset (active high) sets the mask to all ones, empties the stack and clears the overflow flag. A mask bit of 1 means the lane is live.
- R2: With no branch strobe and no join match, `next_pc` is `cur_pc + PC_STEP` (default 1) and the mask is unchanged.
- R3: On a branch where every live lane is taken, `next_pc` is the taken target, the mask is unchanged and no frame is pushed.
- R4: On a branch where no live lane is taken, `next_pc` is the fall-through PC, the mask is unchanged and no frame is pushed.
- R5: Agreement is judged over live lanes only. Taken bits of lanes whose mask bit is 0 have no effect on the outcome or the mask.
- R6: On a split branch with room on the stack, `next_pc` is the taken target in the same cycle. From the next cycle the mask is the taken live lanes only, so the mask never gains a lane and never becomes zero.
- R7: When `cur_pc` equals the top frame's join PC and that frame still holds untaken lanes, `next_pc` is the frame's fall-through PC. From the next cycle the mask is those untaken lanes, and the frame's pending set is emptied.
- R8: When `cur_pc` equals the top frame's join PC and its pending set is empty, the frame is popped, `next_pc` equals `cur_pc`, and from the next cycle the mask is the one that was live before the split.
- R9: A join match takes priority over a branch strobe presented in the same cycle. The branch inputs are then ignored.
- R10: Frames are handled last in, first out. An inner split unwinds completely before the outer frame's join PC is honoured.
- R11: A split while `STACK_DEPTH` frames are held sets `stack_overflow`. The mask and stack stay unchanged and `next_pc` is the fall-through PC. The flag stays set until reset.
- R12: Only the top frame's join PC is compared. With an empty stack, or a PC matching only a deeper frame, the cycle behaves as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Issued instruction is a conditional branch |
| br_taken | input | 32 | Per-lane branch outcome, 1 = taken |
| br_target | input | 32 | Taken-path PC |
| br_fall | input | 32 | Fall-through PC |
| br_join | input | 32 | PC where both paths meet again |
| cur_pc | input | 32 | PC of the instruction issued this cycle |
| active_mask | output | 32 | Live lanes, 1 = live |
| next_pc | output | 32 | PC to fetch next cycle (combinational) |
| stack_overflow | output | 1 | Sticky: a split was refused on a full stack |

## Verification
A corrupted frame field shows up only when the warp next reaches that frame's join PC. A bad fall-through PC or pending set appears as a wrong `next_pc` in the swap cycle and a wrong mask one cycle later. A bad saved mask shows up at the pop, and a bad depth count shows as an early or missing overflow or a join honoured at the wrong nesting level. The bench therefore runs a split and then walks the PC through the join twice. It nests splits with distinct join PCs so a stale top-of-stack pointer changes the result, and it fills the stack to the last slot so an off-by-one in the full test is seen.

// File: rtl/simt_pkg.sv
package simt_pkg;

    localparam int unsigned LANES = 32;
    localparam int unsigned PC_W  = 32;

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [PC_W-1:0]  pc_t;

    // One saved divergence: where to rejoin, who still has to run,
    // where they start, and what mask to bring back at the end.
    typedef struct packed {
        pc_t        join_pc;
        lane_mask_t pend_mask;
        pc_t        fall_pc;
        lane_mask_t saved_mask;
    } reconv_frame_t;

    typedef enum logic [1:0] {
        BR_NONE,
        BR_ALL_TAKEN,
        BR_ALL_FALL,
        BR_SPLIT
    } br_kind_e;

    typedef enum logic [2:0] {
        ACT_SEQ,
        ACT_JUMP,
        ACT_PUSH,
        ACT_OVF,
        ACT_SWAP,
        ACT_POP
    } path_act_e;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_CLEAR_PEND
    } stk_op_e;

    // Outcome of a branch judged over live lanes only.
    function automatic br_kind_e classify_branch(
        input logic       valid,
        input lane_mask_t taken,
        input lane_mask_t live
    );
        lane_mask_t t;
        t = taken & live;
        if (!valid)       return BR_NONE;
        if (t == live)    return BR_ALL_TAKEN;
        if (t == '0)      return BR_ALL_FALL;
        return BR_SPLIT;
    endfunction

endpackage

// File: rtl/simt_branch_classify.sv
module simt_branch_classify
    import simt_pkg::*;
(
    input  logic       br_valid,
    input  lane_mask_t br_taken,
    input  lane_mask_t live_mask,
    output br_kind_e   kind,
    output lane_mask_t taken_live,
    output lane_mask_t fall_live
);

    // Lanes outside the live mask never contribute to either side.
    assign taken_live = br_taken & live_mask;
    assign fall_live  = live_mask & ~br_taken;
    assign kind       = classify_branch(br_valid, br_taken, live_mask);

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_e       op,
    input  reconv_frame_t push_frame,
    output reconv_frame_t top_frame,
    output logic          top_valid,
    output logic          full
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]               depth_q;
    logic [IDX_W-1:0]               wr_idx;
    logic [IDX_W-1:0]               top_idx;
    reconv_frame_t [DEPTH-1:0]      slot_rd;

    assign top_valid = (depth_q != '0);
    assign full      = (depth_q == CNT_W'(DEPTH));
    assign wr_idx    = IDX_W'(depth_q);
    assign top_idx   = IDX_W'(depth_q - CNT_W'(1));

    // Occupancy count; refused pushes and empty pops leave it alone.
    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else begin
            case (op)
                STK_PUSH: if (!full)     depth_q <= depth_q + CNT_W'(1);
                STK_POP:  if (top_valid) depth_q <= depth_q - CNT_W'(1);
                default: ;
            endcase
        end
    end

    // One register per slot; each slot decodes its own write.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        reconv_frame_t slot_q;
        logic          hit_wr;
        logic          hit_top;

        assign hit_wr  = (op == STK_PUSH) && !full && (wr_idx == IDX_W'(g));
        assign hit_top = (op == STK_CLEAR_PEND) && top_valid && (top_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (hit_wr) begin
                slot_q <= push_frame;
            end else if (hit_top) begin
                slot_q.pend_mask <= '0;
            end
        end

        assign slot_rd[g] = slot_q;
    end

    assign top_frame = top_valid ? slot_rd[top_idx] : '0;

endmodule

// File: rtl/simt_path_select.sv
module simt_path_select
    import simt_pkg::*;
#(
    parameter int unsigned PC_STEP = 1
) (
    input  pc_t           cur_pc,
    input  pc_t           br_target,
    input  pc_t           br_fall,
    input  pc_t           br_join,
    input  lane_mask_t    live_mask,
    input  br_kind_e      kind,
    input  lane_mask_t    taken_live,
    input  lane_mask_t    fall_live,
    input  logic          top_valid,
    input  reconv_frame_t top_frame,
    input  logic          stk_full,
    output path_act_e     act,
    output pc_t           next_pc,
    output lane_mask_t    mask_d,
    output logic          mask_we,
    output stk_op_e       stk_op,
    output reconv_frame_t push_frame,
    output logic          ovf_set
);

    logic at_join;

    assign at_join = top_valid && (cur_pc == top_frame.join_pc);

    // Decide the action; a join match outranks any branch this cycle.
    always_comb begin
        act = ACT_SEQ;
        if (at_join) begin
            act = (top_frame.pend_mask != '0) ? ACT_SWAP : ACT_POP;
        end else begin
            case (kind)
                BR_ALL_TAKEN,
                BR_ALL_FALL: act = ACT_JUMP;
                BR_SPLIT:    act = stk_full ? ACT_OVF : ACT_PUSH;
                default:     act = ACT_SEQ;
            endcase
        end
    end

    assign push_frame = '{
        join_pc:    br_join,
        pend_mask:  fall_live,
        fall_pc:    br_fall,
        saved_mask: live_mask
    };

    // Translate the action into PC, mask and stack controls.
    always_comb begin
        next_pc = cur_pc + pc_t'(PC_STEP);
        mask_d  = live_mask;
        mask_we = 1'b0;
        stk_op  = STK_HOLD;
        ovf_set = 1'b0;
        case (act)
            ACT_JUMP: begin
                next_pc = (kind == BR_ALL_TAKEN) ? br_target : br_fall;
            end
            ACT_PUSH: begin
                next_pc = br_target;
                mask_d  = taken_live;
                mask_we = 1'b1;
                stk_op  = STK_PUSH;
            end
            ACT_OVF: begin
                next_pc = br_fall;
                ovf_set = 1'b1;
            end
            ACT_SWAP: begin
                next_pc = top_frame.fall_pc;
                mask_d  = top_frame.pend_mask;
                mask_we = 1'b1;
                stk_op  = STK_CLEAR_PEND;
            end
            ACT_POP: begin
                next_pc = cur_pc;
                mask_d  = top_frame.saved_mask;
                mask_we = 1'b1;
                stk_op  = STK_POP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/simt_reconv_unit.sv
module simt_reconv_unit
    import simt_pkg::*;
#(
    parameter int unsigned STACK_DEPTH = 8,
    parameter int unsigned PC_STEP     = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   br_valid,
    input  logic [LANES-1:0]       br_taken,
    input  logic [PC_W-1:0]        br_target,
    input  logic [PC_W-1:0]        br_fall,
    input  logic [PC_W-1:0]        br_join,
    input  logic [PC_W-1:0]        cur_pc,
    output logic [LANES-1:0]       active_mask,
    output logic [PC_W-1:0]        next_pc,
    output logic                   stack_overflow
);

    lane_mask_t    mask_q;
    logic          ovf_q;
    br_kind_e      kind;
    lane_mask_t    taken_live;
    lane_mask_t    fall_live;
    reconv_frame_t top_frame;
    reconv_frame_t push_frame;
    logic          stk_top_valid;
    logic          stk_full;
    stk_op_e       stk_op;
    path_act_e     act;
    lane_mask_t    mask_d;
    logic          mask_we;
    logic          ovf_set;

    simt_branch_classify u_classify (
        .br_valid   (br_valid),
        .br_taken   (br_taken),
        .live_mask  (mask_q),
        .kind       (kind),
        .taken_live (taken_live),
        .fall_live  (fall_live)
    );

    simt_reconv_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst        (rst),
        .op         (stk_op),
        .push_frame (push_frame),
        .top_frame  (top_frame),
        .top_valid  (stk_top_valid),
        .full       (stk_full)
    );

    simt_path_select #(
        .PC_STEP (PC_STEP)
    ) u_select (
        .cur_pc     (cur_pc),
        .br_target  (br_target),
        .br_fall    (br_fall),
        .br_join    (br_join),
        .live_mask  (mask_q),
        .kind       (kind),
        .taken_live (taken_live),
        .fall_live  (fall_live),
        .top_valid  (stk_top_valid),
        .top_frame  (top_frame),
        .stk_full   (stk_full),
        .act        (act),
        .next_pc    (next_pc),
        .mask_d     (mask_d),
        .mask_we    (mask_we),
        .stk_op     (stk_op),
        .push_frame (push_frame),
        .ovf_set    (ovf_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (ovf_set) begin
            ovf_q <= 1'b1;
        end
    end

    assign active_mask    = mask_q;
    assign stack_overflow = ovf_q;

endmodule

// File: rtl/simt_reconv_checker.sv
module simt_reconv_checker
    import simt_pkg::*;
#(
    parameter int unsigned PC_STEP = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       br_valid,
    input lane_mask_t br_taken,
    input pc_t        br_target,
    input pc_t        br_fall,
    input pc_t        cur_pc,
    input lane_mask_t active_mask,
    input pc_t        next_pc,
    input logic       stack_overflow,
    input logic       top_valid,
    input pc_t        top_join,
    input lane_mask_t top_pend,
    input pc_t        top_fall,
    input logic       stk_full
);

    logic       at_join;
    lane_mask_t t_live;
    logic       is_split;

    assign at_join  = top_valid && (cur_pc == top_join);
    assign t_live   = br_taken & active_mask;
    assign is_split = br_valid && (t_live != '0) && (t_live != active_mask);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (active_mask == '1) && !stack_overflow && !top_valid);

    p_sequential_r2: assert property (@(posedge clk) disable iff (rst)
        (!br_valid && !at_join) |-> (next_pc == cur_pc + pc_t'(PC_STEP)));

    p_uniform_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !at_join && (t_live == active_mask)) |-> (next_pc == br_target));

    p_uniform_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !at_join && !is_split) |=> $stable(active_mask));

    p_uniform_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (br_valid && !at_join && (t_live == '0)) |-> (next_pc == br_fall));

    p_split_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (is_split && !at_join && !stk_full) |=> (active_mask == $past(t_live)));

    p_mask_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        active_mask != '0);

    p_swap_pc_r7: assert property (@(posedge clk) disable iff (rst)
        (at_join && (top_pend != '0)) |-> (next_pc == top_fall));

    p_swap_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (at_join && (top_pend != '0)) |=> (active_mask == $past(top_pend)));

    p_pop_pc_r8: assert property (@(posedge clk) disable iff (rst)
        (at_join && (top_pend == '0)) |-> (next_pc == cur_pc));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        (is_split && !at_join && stk_full) |=> (stack_overflow && $stable(active_mask)));

    p_sticky_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        stack_overflow |=> stack_overflow);

endmodule

bind simt_reconv_unit simt_reconv_checker #(
    .PC_STEP (PC_STEP)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .br_valid       (br_valid),
    .br_taken       (br_taken),
    .br_target      (br_target),
    .br_fall        (br_fall),
    .cur_pc         (cur_pc),
    .active_mask    (active_mask),
    .next_pc        (next_pc),
    .stack_overflow (stack_overflow),
    .top_valid      (stk_top_valid),
    .top_join       (top_frame.join_pc),
    .top_pend       (top_frame.pend_mask),
    .top_fall       (top_frame.fall_pc),
    .stk_full       (stk_full)
);

// File: tb/simt_reconv_unit_tb.sv
`timescale 1ns/1ps
module simt_reconv_unit_tb;
    import simt_pkg::*;

    localparam int unsigned DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       br_valid;
    lane_mask_t br_taken;
    pc_t        br_target, br_fall, br_join, cur_pc;
    lane_mask_t active_mask;
    pc_t        next_pc;
    logic       stack_overflow;

    always #2 clk = ~clk;

    simt_reconv_unit #(.STACK_DEPTH(DEPTH), .PC_STEP(1)) u_dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
        .br_target(br_target), .br_fall(br_fall), .br_join(br_join),
        .cur_pc(cur_pc), .active_mask(active_mask), .next_pc(next_pc),
        .stack_overflow(stack_overflow)
    );

    int checks = 0;
    int errors = 0;

    // Scoreboard queues: expected values for one issue cycle each.
    pc_t        q_pc[$];
    lane_mask_t q_mask[$];
    logic       q_ovf[$];
    string      q_tag[$];

    // Reference model state.
    lane_mask_t    m_mask;
    logic          m_ovf;
    reconv_frame_t m_stk[$];

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; br_valid = 1'b0; br_taken = '0;
        br_target = '0; br_fall = '0; br_join = '0; cur_pc = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_mask = '1; m_ovf = 1'b0; m_stk.delete();
    endtask

    // Driver: apply one issue cycle and queue what the requirements predict.
    task automatic drive(input logic v, input lane_mask_t tk, input pc_t tgt,
                         input pc_t fl, input pc_t jn, input pc_t pc, input string tag);
        pc_t        exp_pc;
        lane_mask_t ta;
        logic       at_join;
        @(negedge clk);
        br_valid = v; br_taken = tk; br_target = tgt; br_fall = fl;
        br_join = jn; cur_pc = pc;
        q_mask.push_back(m_mask);
        q_ovf.push_back(m_ovf);
        q_tag.push_back(tag);
        at_join = (m_stk.size() > 0) && (pc == m_stk[m_stk.size()-1].join_pc);
        exp_pc = pc + 1;
        if (at_join) begin
            if (m_stk[m_stk.size()-1].pend_mask != '0) begin
                exp_pc = m_stk[m_stk.size()-1].fall_pc;
                m_mask = m_stk[m_stk.size()-1].pend_mask;
                m_stk[m_stk.size()-1].pend_mask = '0;
            end else begin
                exp_pc = pc;
                m_mask = m_stk[m_stk.size()-1].saved_mask;
                void'(m_stk.pop_back());
            end
        end else if (v) begin
            ta = tk & m_mask;
            if (ta == m_mask) exp_pc = tgt;
            else if (ta == '0) exp_pc = fl;
            else if (m_stk.size() == DEPTH) begin
                exp_pc = fl;
                m_ovf = 1'b1;
            end else begin
                m_stk.push_back('{join_pc: jn, pend_mask: m_mask & ~tk,
                                  fall_pc: fl, saved_mask: m_mask});
                m_mask = ta;
                exp_pc = tgt;
            end
        end
        q_pc.push_back(exp_pc);
    endtask

    task automatic step(input pc_t pc, input string tag);
        drive(1'b0, '0, '0, '0, '0, pc, tag);
    endtask

    // Monitor: sample ahead of the next rising edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (q_pc.size() > 0) begin
                pc_t e_pc; lane_mask_t e_mask; logic e_ovf; string t;
                e_pc = q_pc.pop_front(); e_mask = q_mask.pop_front();
                e_ovf = q_ovf.pop_front(); t = q_tag.pop_front();
                checks++;
                if (next_pc !== e_pc) begin
                    errors++;
                    $display("FAIL %s next_pc actual=%h expected=%h", t, next_pc, e_pc);
                end
                checks++;
                if (active_mask !== e_mask) begin
                    errors++;
                    $display("FAIL %s active_mask actual=%h expected=%h", t, active_mask, e_mask);
                end
                checks++;
                if (stack_overflow !== e_ovf) begin
                    errors++;
                    $display("FAIL %s stack_overflow actual=%b expected=%b", t, stack_overflow, e_ovf);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        do_reset();
        step(32'h100, "R1 reset state");
        step(32'h101, "R2 sequential");
        drive(1'b1, '1, 32'h400, 32'h103, 32'h0, 32'h102, "R3 uniform taken");
        drive(1'b1, '0, 32'h500, 32'h401, 32'h0, 32'h400, "R4 uniform fall");
        // Split, walk taken path, swap, untaken path, pop.
        drive(1'b1, 32'h0000FFFF, 32'h200, 32'h402, 32'h300, 32'h401, "R6 split push");
        step(32'h200, "R6 taken lanes only");
        step(32'h201, "R6 taken path continues");
        step(32'h300, "R7 swap at join");
        step(32'h402, "R7 untaken lanes live");
        drive(1'b1, 32'h0000_0F0F, 32'h600, 32'h404, 32'h0, 32'h403, "R5 inactive bits ignored fall");
        drive(1'b1, 32'hFFFF_0001, 32'h410, 32'h405, 32'h0, 32'h404, "R5 inactive bits ignored taken");
        step(32'h300, "R8 pop at join");
        step(32'h300, "R12 empty stack no join");
        // Join beats a branch strobe in the same cycle.
        drive(1'b1, 32'h1, 32'h700, 32'h601, 32'h800, 32'h600, "R6 split one lane");
        drive(1'b1, '1, 32'h900, 32'h801, 32'h123, 32'h800, "R9 join beats branch");
        step(32'h601, "R9 untaken lanes after swap");
        drive(1'b1, '1, 32'h950, 32'h951, 32'h0, 32'h800, "R9 pop beats branch");
        step(32'h800, "R8 restored mask");
        // Nesting with distinct join PCs.
        drive(1'b1, 32'h00FF00FF, 32'hA00, 32'hB00, 32'hC00, 32'h9FF, "R10 outer split");
        drive(1'b1, 32'h000000FF, 32'hA80, 32'hA01, 32'hA40, 32'hA00, "R10 inner split");
        step(32'hC00, "R12 only top frame compared");
        step(32'hA40, "R10 inner swap");
        step(32'hA40, "R10 inner pop");
        step(32'hA40, "R10 past inner join");
        step(32'hC00, "R10 outer swap");
        step(32'hC00, "R10 outer pop");
        step(32'hC00, "R10 unwound");
        // Fill the stack, then one split too many.
        for (int i = 0; i < DEPTH; i++) begin
            drive(1'b1, '1 << (i + 1), pc_t'(32'h1000 + i + 1), pc_t'(32'h3000 + i),
                  pc_t'(32'h2000 + i), pc_t'(32'h1000 + i), "R10 fill stack");
        end
        drive(1'b1, '1 << (DEPTH + 1), 32'h1100, 32'h3100, 32'h2100, 32'h1010, "R11 split on full stack");
        step(32'h3100, "R11 flag set, mask held");
        drive(1'b1, '1, 32'h1200, 32'h3200, 32'h0, 32'h3101, "R11 uniform still works while full");
        step(32'h1200, "R11 sticky flag");
        step(32'h2000 + DEPTH - 1, "R11 top frame unchanged swap");
        do_reset();
        step(32'h40, "R1 reset clears overflow");
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule